// File: doc/BRIEF.md
# Expansion Bus Bridge Cycle Controller

This block sits between a local asynchronous-style bus master and a remote multiplexed expansion bus. It carries single read and write cycles from the local side to the remote side. When the local master raises its address strobe together with one or both data strobes, the block reads the strobe pattern, address bit 1 and the long-word qualifier. It re-encodes them into a one-bit remote transfer size and the two lowest bits of the remote address word. It then requests the remote bus, drives one address phase and runs one data phase.

Parity travels with every remote word the bridge drives. It covers the address word and write data. On reads it is checked against the bit the remote target returns, and a mismatch ends the local cycle with a bus error. If a remote device asks for the local bus while the bridge is still waiting for its remote grant, both sides would wait on each other. The bridge breaks this deadlock by dropping its request and ending the local cycle with a bus error. It also records the event in a sticky backoff flag, which can raise an interrupt.

Each local cycle ends with either acknowledge or bus error. That response is held until the master releases both data strobes.

Top module: `xbus_bridge_ctl`

## Requirements
- R1: A byte access (exactly one data strobe asserted, long-word deasserted) gives remote size 0 and low address bits {A01, ds[0]}. Strobe encoding is ds[1] for the even byte and ds[0] for the odd byte, so bytes 0 to 3 give 00, 01, 10 and 11.
- R2: A 16-bit access (ds = 11, long-word deasserted) gives remote size 1 and low address bits {A01, 0}.
- R3: A 32-bit access (ds = 11, A01 = 0, long-word asserted) gives remote size 1 and low address bits 11.
- R4: Any other started combination (long-word with A01 = 1, or long-word with a single strobe) answers with a bus error, and the remote request is never raised.
- R5: During the address phase, the bridge drives the address word and a parity bit, with the two together having an odd number of ones. Address bits 31..2 come from the local address.
- R6: In the data phase of a write, the bridge drives the write data and its odd parity. In the data phase of a read, it drives neither the address/data lines nor the parity line (both output enables low).
- R7: A read whose returned word and parity bit have odd total parity ends with acknowledge and presents the returned word. A read with even total parity ends with a bus error.
- R8: If the remote side requests the local bus while the bridge is arbitrating, the bridge drops its request on the next cycle and signals a bus error. This also happens when the grant arrives in the same cycle.
- R9: Every backoff sets a sticky flag. The interrupt output is the flag gated by the enable input. A clear pulse resets the flag, and a backoff in the same cycle as the clear wins.
- R10: Acknowledge and bus error are never asserted together. Either one holds while any data strobe stays asserted, and the next cycle can start only after the strobes are released.
- R11: After reset, every output is low.
- R12: The remote request stays high from arbitration through the address phase and the data phase. The address phase lasts exactly one cycle and is followed by the data phase. The request drops once the data phase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| loc_as | input | 1 | Local address strobe |
| loc_ds | input | 2 | Local data strobes, [1] even byte, [0] odd byte |
| loc_lword | input | 1 | Local long-word qualifier |
| loc_write | input | 1 | Local cycle is a write |
| loc_addr | input | ADW-1 | Local address bits ADW-1..1 |
| loc_wdata | input | DW | Local write data |
| loc_rdata | output | DW | Read data returned to the local master |
| loc_ack | output | 1 | Local cycle acknowledge |
| loc_berr | output | 1 | Local cycle bus error |
| rb_req | output | 1 | Remote bus request |
| rb_grant | input | 1 | Remote bus grant |
| rb_lreq | input | 1 | Remote device requests the local bus |
| rb_addr_ph | output | 1 | Remote address phase |
| rb_data_ph | output | 1 | Remote data phase |
| rb_write | output | 1 | Remote cycle direction |
| rb_size | output | 1 | Remote transfer size bit |
| rb_ad_out | output | ADW | Remote address/data driven value |
| rb_ad_oe | output | 1 | Remote address/data output enable |
| rb_ad_in | input | ADW | Remote address/data received value |
| rb_par_out | output | 1 | Remote parity driven value |
| rb_par_oe | output | 1 | Remote parity output enable |
| rb_par_in | input | 1 | Remote parity received value |
| rb_ready | input | 1 | Remote target completes the data phase |
| irq_en | input | 1 | Backoff interrupt enable |
| irq_clr | input | 1 | Backoff flag clear pulse |
| bo_irq | output | 1 | Backoff interrupt request |

## Verification
The bench builds the block with its defaults: four byte lanes (a 32-bit multiplexed word) and odd parity. These settings cover every row of the lane mapping, including both half-word positions, the long-word code and the rejected long-word combinations. A behavioural model follows each local cycle from the strobes to the remote phases. Runs vary the grant delay, return words with good and bad parity, trigger backoffs with and without the interrupt enabled and with the grant arriving at the same time, and hold the strobes past the response.

// File: rtl/xbb_pkg.sv
package xbb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ARB  = 3'd1,
      ST_ADDR = 3'd2,
      ST_DATA = 3'd3,
      ST_DONE = 3'd4,
      ST_BERR = 3'd5
   } xbb_state_e;

   typedef struct packed {
      logic       legal;
      logic       size;
      logic [1:0] low;
   } xbb_lane_t;

endpackage

// File: rtl/xbb_lane_map.sv
module xbb_lane_map
   import xbb_pkg::*;
(
   input  logic [1:0] ds,
   input  logic       a01,
   input  logic       lword,
   output xbb_lane_t  lane
);
   // R1 R2 R3 R4: qualifier re-encoding
   always_comb begin
      lane = '0;
      unique case ({lword, ds})
         3'b010:  lane = '{legal: 1'b1, size: 1'b0, low: {a01, 1'b0}};
         3'b001:  lane = '{legal: 1'b1, size: 1'b0, low: {a01, 1'b1}};
         3'b011:  lane = '{legal: 1'b1, size: 1'b1, low: {a01, 1'b0}};
         3'b111:  lane = '{legal: !a01, size: 1'b1, low: 2'b11};
         default: lane = '0;
      endcase
   end
endmodule

// File: rtl/xbb_parity.sv
module xbb_parity #(
   parameter int W       = 32,
   parameter bit PAR_ODD = 1'b1
) (
   input  logic [W-1:0] word,
   output logic         par
);
   generate
      if (PAR_ODD) begin : g_odd
         assign par = ~^word;
      end else begin : g_even
         assign par = ^word;
      end
   endgenerate
endmodule

// File: rtl/xbb_seq.sv
module xbb_seq
   import xbb_pkg::*;
#(
   parameter int ADW = 32,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           ds_any,
   input  xbb_lane_t      lane,
   input  logic           wr_in,
   input  logic [ADW-1:2] addr_hi,
   input  logic [DW-1:0]  wdata_in,
   input  logic           grant,
   input  logic           lreq,
   input  logic           ready,
   input  logic [DW-1:0]  rx_word,
   input  logic           rx_par_ok,
   output xbb_state_e     state,
   output logic [ADW-1:0] addr_q,
   output logic [DW-1:0]  wdata_q,
   output logic [DW-1:0]  rdata_q,
   output logic           size_q,
   output logic           wr_q,
   output logic           backoff
);
   assign backoff = (state == ST_ARB) && lreq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         size_q  <= 1'b0;
         wr_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  if (lane.legal) begin
                     addr_q  <= {addr_hi, lane.low};
                     size_q  <= lane.size;
                     wr_q    <= wr_in;
                     wdata_q <= wdata_in;
                     state   <= ST_ARB;
                  end else begin
                     state <= ST_BERR;
                  end
               end
            end
            ST_ARB: begin
               // R8: a request for the local bus outranks a grant
               if (lreq)       state <= ST_BERR;
               else if (grant) state <= ST_ADDR;
            end
            ST_ADDR: state <= ST_DATA;
            ST_DATA: begin
               if (ready) begin
                  if (!wr_q) rdata_q <= rx_word;
                  state <= (wr_q || rx_par_ok) ? ST_DONE : ST_BERR;
               end
            end
            ST_DONE, ST_BERR: begin
               if (!ds_any) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xbb_bo_flag.sv
module xbb_bo_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set | (flag_q & ~clr);
   end

   assign irq = flag_q & en;
endmodule

// File: rtl/xbus_bridge_ctl.sv
module xbus_bridge_ctl
   import xbb_pkg::*;
#(
   parameter int LANES   = 4,
   parameter bit PAR_ODD = 1'b1,
   localparam int DW     = 8 * LANES,
   localparam int ADW    = DW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           loc_as,
   input  logic [1:0]     loc_ds,
   input  logic           loc_lword,
   input  logic           loc_write,
   input  logic [ADW-1:1] loc_addr,
   input  logic [DW-1:0]  loc_wdata,
   output logic [DW-1:0]  loc_rdata,
   output logic           loc_ack,
   output logic           loc_berr,
   output logic           rb_req,
   input  logic           rb_grant,
   input  logic           rb_lreq,
   output logic           rb_addr_ph,
   output logic           rb_data_ph,
   output logic           rb_write,
   output logic           rb_size,
   output logic [ADW-1:0] rb_ad_out,
   output logic           rb_ad_oe,
   input  logic [ADW-1:0] rb_ad_in,
   output logic           rb_par_out,
   output logic           rb_par_oe,
   input  logic           rb_par_in,
   input  logic           rb_ready,
   input  logic           irq_en,
   input  logic           irq_clr,
   output logic           bo_irq
);
   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("xbus_bridge_ctl: lane mapping is defined for four byte lanes");
      end
   endgenerate

   xbb_lane_t      lane;
   xbb_state_e     state;
   logic [ADW-1:0] addr_q;
   logic [DW-1:0]  wdata_q;
   logic [DW-1:0]  rdata_q;
   logic           size_q, wr_q, backoff;
   logic           ds_any, start;
   logic           tx_par, rx_par, drive;
   logic [ADW-1:0] tx_word;

   assign ds_any = |loc_ds;
   assign start  = loc_as & ds_any;

   xbb_lane_map u_map (
      .ds    (loc_ds),
      .a01   (loc_addr[1]),
      .lword (loc_lword),
      .lane  (lane)
   );

   xbb_seq #(.ADW(ADW), .DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ds_any    (ds_any),
      .lane      (lane),
      .wr_in     (loc_write),
      .addr_hi   (loc_addr[ADW-1:2]),
      .wdata_in  (loc_wdata),
      .grant     (rb_grant),
      .lreq      (rb_lreq),
      .ready     (rb_ready),
      .rx_word   (rb_ad_in),
      .rx_par_ok (rx_par == rb_par_in),
      .state     (state),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .rdata_q   (rdata_q),
      .size_q    (size_q),
      .wr_q      (wr_q),
      .backoff   (backoff)
   );

   assign drive   = (state == ST_ADDR) || ((state == ST_DATA) && wr_q);
   assign tx_word = (state == ST_ADDR) ? addr_q :
                    (drive ? wdata_q : '0);

   xbb_parity #(.W(ADW), .PAR_ODD(PAR_ODD)) u_tx_par (
      .word (tx_word),
      .par  (tx_par)
   );

   xbb_parity #(.W(ADW), .PAR_ODD(PAR_ODD)) u_rx_par (
      .word (rb_ad_in),
      .par  (rx_par)
   );

   xbb_bo_flag u_bo (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (backoff),
      .clr   (irq_clr),
      .en    (irq_en),
      .irq   (bo_irq)
   );

   assign loc_rdata  = rdata_q;
   assign loc_ack    = (state == ST_DONE);
   assign loc_berr   = (state == ST_BERR);
   assign rb_req     = (state == ST_ARB) || (state == ST_ADDR) || (state == ST_DATA);
   assign rb_addr_ph = (state == ST_ADDR);
   assign rb_data_ph = (state == ST_DATA);
   assign rb_write   = wr_q;
   assign rb_size    = size_q;
   assign rb_ad_out  = tx_word;
   assign rb_ad_oe   = drive;
   assign rb_par_out = drive & tx_par;
   assign rb_par_oe  = drive;
endmodule

// File: rtl/xbb_checker.sv
module xbb_checker #(
   parameter int ADW     = 32,
   parameter bit PAR_ODD = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [1:0]     loc_ds,
   input logic           loc_ack,
   input logic           loc_berr,
   input logic           rb_req,
   input logic           rb_lreq,
   input logic           rb_addr_ph,
   input logic           rb_data_ph,
   input logic           rb_write,
   input logic [ADW-1:0] rb_ad_out,
   input logic           rb_ad_oe,
   input logic           rb_par_out,
   input logic           rb_par_oe,
   input logic           irq_en,
   input logic           bo_irq
);
   logic arbitrating;
   assign arbitrating = rb_req && !rb_addr_ph && !rb_data_ph;

   assert_resp_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_ack && loc_berr));

   assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((loc_ack || loc_berr) && (|loc_ds)) |=> (loc_ack || loc_berr));

   assert_driven_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rb_par_oe |-> ((^{rb_ad_out, rb_par_out}) == PAR_ODD));

   assert_read_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_data_ph && !rb_write) |-> (!rb_ad_oe && !rb_par_oe));

   assert_addr_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rb_addr_ph |-> (rb_ad_oe && rb_par_oe));

   assert_backoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (arbitrating && rb_lreq) |=> (!rb_req && loc_berr));

   assert_backoff_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (arbitrating && rb_lreq) |=> (bo_irq || !irq_en));

   assert_phase_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rb_addr_ph |=> (rb_data_ph && rb_req));
endmodule

bind xbus_bridge_ctl xbb_checker #(.ADW(ADW), .PAR_ODD(PAR_ODD)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .loc_ds     (loc_ds),
   .loc_ack    (loc_ack),
   .loc_berr   (loc_berr),
   .rb_req     (rb_req),
   .rb_lreq    (rb_lreq),
   .rb_addr_ph (rb_addr_ph),
   .rb_data_ph (rb_data_ph),
   .rb_write   (rb_write),
   .rb_ad_out  (rb_ad_out),
   .rb_ad_oe   (rb_ad_oe),
   .rb_par_out (rb_par_out),
   .rb_par_oe  (rb_par_oe),
   .irq_en     (irq_en),
   .bo_irq     (bo_irq)
);

// File: tb/xbus_bridge_ctl_tb_top.sv
`timescale 1ns/1ps
module xbus_bridge_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        loc_as = 0, loc_lword = 0, loc_write = 0;
   logic [1:0]  loc_ds = 0;
   logic [31:1] loc_addr = 0;
   logic [31:0] loc_wdata = 0, rb_ad_in = 0;
   logic        rb_grant = 0, rb_lreq = 0, rb_par_in = 0, rb_ready = 0;
   logic        irq_en = 0, irq_clr = 0;
   logic [31:0] loc_rdata, rb_ad_out;
   logic        loc_ack, loc_berr, rb_req, rb_addr_ph, rb_data_ph;
   logic        rb_write, rb_size, rb_ad_oe, rb_par_out, rb_par_oe, bo_irq;

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;
   string cur_tag = "R1";

   always #2 clk = ~clk;

   xbus_bridge_ctl dut_i (.*);

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int          m_st = 0;   // 0 idle 1 arb 2 addr 3 data 4 done 5 berr
   logic [31:0] m_addr = 0, m_wdata = 0, m_rdata = 0;
   logic        m_size = 0, m_wr = 0, m_flag = 0;

   function automatic void lane_rule(input logic [1:0] ds, input logic a01, input logic lw,
                                     output bit ok, output logic sz, output logic [1:0] lo);
      ok = 0; sz = 0; lo = 0;
      if (!lw && ds == 2'b10)      begin ok = 1; sz = 0; lo = {a01, 1'b0}; end
      else if (!lw && ds == 2'b01) begin ok = 1; sz = 0; lo = {a01, 1'b1}; end
      else if (!lw && ds == 2'b11) begin ok = 1; sz = 1; lo = {a01, 1'b0}; end
      else if (lw && ds == 2'b11 && !a01) begin ok = 1; sz = 1; lo = 2'b11; end
   endfunction

   always @(posedge clk) begin
      bit ok; logic sz; logic [1:0] lo; bit setv;
      if (!rst_n) begin
         m_st = 0; m_flag = 0; m_rdata = 0; m_addr = 0; m_wdata = 0; m_size = 0; m_wr = 0;
      end else begin
         setv = (m_st == 1) && rb_lreq;
         case (m_st)
            0: if (loc_as && loc_ds != 0) begin
                  lane_rule(loc_ds, loc_addr[1], loc_lword, ok, sz, lo);
                  if (ok) begin
                     m_addr = {loc_addr[31:2], lo}; m_size = sz; m_wr = loc_write;
                     m_wdata = loc_wdata; m_st = 1;
                  end else m_st = 5;
               end
            1: if (rb_lreq) m_st = 5; else if (rb_grant) m_st = 2;
            2: m_st = 3;
            3: if (rb_ready) begin
                  if (!m_wr) m_rdata = rb_ad_in;
                  if (m_wr || (^{rb_ad_in, rb_par_in})) m_st = 4; else m_st = 5;
               end
            default: if (loc_ds == 0) m_st = 0;
         endcase
         m_flag = (m_flag && !irq_clr) || setv;
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         chk("R10", "loc_ack", loc_ack, m_st == 4);
         chk("R10", "loc_berr", loc_berr, m_st == 5);
         chk("R12", "rb_req", rb_req, m_st >= 1 && m_st <= 3);
         chk("R12", "rb_addr_ph", rb_addr_ph, m_st == 2);
         chk("R12", "rb_data_ph", rb_data_ph, m_st == 3);
         chk("R6", "rb_ad_oe", rb_ad_oe, m_st == 2 || (m_st == 3 && m_wr));
         chk("R6", "rb_par_oe", rb_par_oe, m_st == 2 || (m_st == 3 && m_wr));
         chk("R9", "bo_irq", bo_irq, m_flag && irq_en);
         if (m_st == 2) begin
            chk(cur_tag, "addr word", rb_ad_out, m_addr);
            chk(cur_tag, "size", rb_size, m_size);
            chk("R5", "addr parity", rb_par_out, ~^m_addr);
         end
         if (m_st == 3 && m_wr) begin
            chk("R6", "write data", rb_ad_out, m_wdata);
            chk("R6", "write parity", rb_par_out, ~^m_wdata);
         end
         if (m_st == 4 && !m_wr) chk("R7", "read data", loc_rdata, m_rdata);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog actual=%0d expected<=50000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   // mode: 0 grant, 1 local-bus request, 2 both in the same cycle
   task automatic xfer(string tag, logic [1:0] ds, logic a01, logic lw, logic wr,
                       logic [31:0] addr, logic [31:0] wd, logic [31:0] rd, bit badpar,
                       int gdelay, int mode, int hold, bit exp_berr);
      bit got_ack = 0, got_berr = 0;
      cur_tag = tag;
      loc_as = 1; loc_ds = ds; loc_lword = lw; loc_write = wr;
      loc_addr = {addr[31:2], a01}; loc_wdata = wd;
      step();
      for (int i = 0; i < gdelay; i++) step();
      rb_grant = (mode != 1); rb_lreq = (mode != 0);
      for (int i = 0; i < 40; i++) begin
         if (rb_data_ph) begin
            rb_ready = 1; rb_ad_in = rd; rb_par_in = (~^rd) ^ badpar;
         end else rb_ready = 0;
         if (loc_ack || loc_berr) begin
            got_ack = loc_ack; got_berr = loc_berr;
            break;
         end
         step();
      end
      rb_ready = 0; rb_lreq = 0;
      for (int i = 0; i < hold; i++) begin
         step();
         chk(tag, "response held with strobes", loc_ack | loc_berr, 1'b1);
      end
      chk(tag, "bus error outcome", got_berr, exp_berr);
      chk(tag, "acknowledge outcome", got_ack, !exp_berr);
      if (!exp_berr && !wr) chk(tag, "returned word", loc_rdata, rd);
      loc_as = 0; loc_ds = 0; rb_grant = 0;
      step();
      chk("R10", "idle after release", loc_ack | loc_berr | rb_req, 1'b0);
      step();
   endtask

   initial begin
      step(); step();
      chk("R11", "outputs in reset", {loc_ack, loc_berr, rb_req, rb_addr_ph, rb_data_ph,
          rb_ad_oe, rb_par_oe, bo_irq, rb_size, rb_write}, 10'd0);
      rst_n = 1; irq_en = 1;
      step();
      // R1 byte lanes
      xfer("R1", 2'b10, 0, 0, 1, 32'h1234_5670, 32'hA5, 0, 0, 0, 0, 0, 0);
      xfer("R1", 2'b01, 0, 0, 1, 32'h1234_5670, 32'h5A00, 0, 0, 1, 0, 0, 0);
      xfer("R1", 2'b10, 1, 0, 1, 32'hFFFF_FFFC, 32'h00C3_0000, 0, 0, 2, 0, 0, 0);
      xfer("R1", 2'b01, 1, 0, 0, 32'h8000_0004, 0, 32'h3C00_0000, 0, 0, 0, 0, 0);
      // R2 half words, R7 good parity
      xfer("R2", 2'b11, 0, 0, 0, 32'h0F0F_0000, 0, 32'hDEAD_BEEF, 0, 3, 0, 0, 0);
      xfer("R2", 2'b11, 1, 0, 1, 32'h0F0F_0008, 32'h1357_9BDF, 0, 0, 0, 0, 0, 0);
      // R3 long word
      xfer("R3", 2'b11, 0, 1, 1, 32'hCAFE_0010, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
      xfer("R3", 2'b11, 0, 1, 0, 32'hCAFE_0020, 0, 32'h0000_0001, 0, 1, 0, 0, 0);
      // R7 bad parity
      xfer("R7", 2'b11, 0, 1, 0, 32'h4000_0000, 0, 32'h7777_7777, 1, 0, 0, 0, 1);
      // R4 illegal combinations
      xfer("R4", 2'b11, 1, 1, 1, 32'h4000_0000, 32'h1, 0, 0, 0, 0, 0, 1);
      xfer("R4", 2'b10, 0, 1, 0, 32'h4000_0000, 0, 0, 0, 0, 0, 0, 1);
      // R8 R9 backoff with the interrupt enabled
      xfer("R8", 2'b11, 0, 0, 1, 32'h2000_0000, 32'h2, 0, 0, 2, 1, 0, 1);
      chk("R9", "interrupt after backoff", bo_irq, 1'b1);
      irq_clr = 1; step(); irq_clr = 0; step();
      chk("R9", "interrupt cleared", bo_irq, 1'b0);
      // R8 grant and local-bus request together; R9 masked then unmasked
      irq_en = 0;
      xfer("R8", 2'b01, 1, 0, 0, 32'h2000_0000, 0, 32'h9, 0, 0, 2, 0, 1);
      chk("R9", "masked interrupt", bo_irq, 1'b0);
      irq_en = 1; step();
      chk("R9", "sticky flag shows when enabled", bo_irq, 1'b1);
      irq_clr = 1; step(); irq_clr = 0; step();
      // R10 strobes held after the response
      xfer("R10", 2'b11, 0, 0, 0, 32'h0000_0100, 0, 32'h0BAD_F00D, 0, 0, 0, 5, 0);
      xfer("R10", 2'b11, 1, 1, 0, 32'h0000_0100, 0, 0, 0, 0, 0, 4, 1);
      // R12 long grant wait
      xfer("R12", 2'b10, 0, 0, 1, 32'h7654_3210, 32'h11, 0, 0, 8, 0, 0, 0);
      step(); step();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule